// File: doc/BRIEF.md
# Internal Bus Ownership Arbiter for Two DMA Channels

This block decides who drives a chip's single internal bus. There are four possible owners: the CPU, two DMA channels and an external device that asks to hold the bus. Every requester gets its own grant output, and exactly one of them is active in every cycle. The CPU is the default owner and keeps the bus whenever nobody else wins.

Ownership can move only at a bus-cycle boundary, which the bus interface marks with a one-cycle strobe. A DMA channel that wins keeps the bus for two consecutive bus cycles, so its read and its write stay together. When both channels request, the winner is either fixed by a configuration bit or chosen by turns.

An external hold request beats DMA. DMA beats the CPU, but no takeover may cut into a locked CPU sequence or into the two halves of a CPU word access at an odd address. A non-maskable interrupt sets a sticky halt flag. The flag keeps both channels off the bus until software clears it. Ordinary interrupts are not an input of this block, so they cannot take the bus from a running DMA.

Top module: `dma_bus_arbiter`

## Requirements
- R1: Synchronous active-low reset gives the bus to the CPU and clears the halt flag. In grant encoding {hold_ack, dma_gnt[1], dma_gnt[0], cpu_gnt}, the reset value is 0001.
- R2: The bus owner changes only on a clock edge at which `bus_cycle_end` is 1. On every other edge the grants hold their values.
- R3: After a DMA channel is granted, it keeps the bus across the next `bus_cycle_end` whatever its request, hold or NMI do. The owner is decided again only at the boundary after that one.
- R4: With `arb_mode`=0 and both `dma_req` bits set, the channel named by `fixed_winner` wins (0 = channel 0, 1 = channel 1). With a single request, that channel is granted.
- R5: With `arb_mode`=1 and both channels requesting, the channel granted most recently loses the next decision. After reset, channel 0 is treated as the winner of the first such tie.
- R6: While the CPU owns the bus and `cpu_locked` is 1, a boundary leaves the bus with the CPU, even if DMA or hold requests are pending.
- R7: While the CPU owns the bus and `cpu_odd_split` is 1, a boundary leaves the bus with the CPU, even if DMA or hold requests are pending.
- R8: At a decision point, `hold_req` wins over any DMA request and over a halt. The hold owner keeps the bus at each boundary while `hold_req` stays high.
- R9: `nmi`=1 sets `dma_halted` at the next edge, and from then on no DMA channel is granted at any decision. `halt_clear`=1 with `nmi`=0 clears the flag. If both are high, `nmi` wins.
- R10: Exactly one of `cpu_gnt`, `dma_gnt[0]`, `dma_gnt[1]`, `hold_ack` is 1 in every cycle. At a decision with no hold and no grantable DMA request, the CPU is the owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cycle_end | input | 1 | One-cycle strobe at a bus-cycle boundary |
| dma_req | input | 2 | Transfer requests, bit n from channel n |
| arb_mode | input | 1 | 0 fixed channel priority, 1 alternating |
| fixed_winner | input | 1 | Channel that wins ties in fixed mode |
| cpu_locked | input | 1 | CPU is inside a locked access sequence |
| cpu_odd_split | input | 1 | CPU is between the halves of an odd-address word access |
| hold_req | input | 1 | External bus hold request |
| nmi | input | 1 | Non-maskable interrupt request |
| halt_clear | input | 1 | Software clear of the DMA halt flag |
| cpu_gnt | output | 1 | CPU owns the bus |
| dma_gnt | output | 2 | Channel n owns the bus |
| hold_ack | output | 1 | External holder owns the bus |
| dma_halted | output | 1 | DMA is blocked after an NMI |

## Verification
The bench targets the cases where a takeover must wait:

- A hold or NMI that arrives during the second half of a DMA pair must not take the bus until the pair is done. A design that decides at every boundary would split the read from the write.
- A lock or an odd-address split must keep the CPU on the bus. A design that ignored them would grant DMA or hold in the middle of the CPU's access.
- Fixed mode must keep granting the same channel, and alternating mode must swap channels on each tie. A wrong last-winner update would repeat a channel or starve one.

It also checks that the halt flag is sticky, that NMI wins when it arrives together with a clear, and that nothing moves on a cycle without a boundary strobe.

// File: rtl/dma_arb_pkg.sv
// Package: shared types and sizes for the bus ownership arbiter.
// Assumes exactly two DMA channels; owner encoding is internal only.
package dma_arb_pkg;
    localparam int NUM_CH = 2;
    localparam int CH_W   = $clog2(NUM_CH);

    typedef enum logic [1:0] {
        OWN_CPU  = 2'd0,
        OWN_CH0  = 2'd1,
        OWN_CH1  = 2'd2,
        OWN_HOLD = 2'd3
    } owner_t;
endpackage

// File: rtl/dma_chan_pick.sv
// Module: chooses which DMA channel wins a decision.
// Fixed mode: a configuration bit names the tie winner. Alternating mode:
// the last granted channel loses a tie. Assumes NUM_CH == 2.
module dma_chan_pick
    import dma_arb_pkg::*;
#(
    parameter int CHANNELS = NUM_CH
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CHANNELS-1:0] req,
    input  logic                alt_mode,
    input  logic                fixed_ch,
    input  logic                take,
    output logic                any_req,
    output logic                pick
);
    logic last_ch;
    logic tie;

    // Combine requests and resolve ties by the selected rule.
    always_comb begin
        any_req = |req;
        tie     = &req;
        if (tie)
            pick = alt_mode ? ~last_ch : fixed_ch;
        else
            pick = req[1];
    end

    // Remember the most recently granted channel; reset favours channel 0 first.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_ch <= 1'b1;
        else if (take)
            last_ch <= pick;
    end

    // R5
    alt_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && alt_mode && tie) |=> (last_ch != $past(last_ch)));

    // R4
    fixed_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !alt_mode && tie) |=> (last_ch == $past(fixed_ch)));
endmodule

// File: rtl/dma_halt_flag.sv
// Module: sticky DMA halt flag set by NMI, cleared by software.
// Assumes NMI has priority over a simultaneous clear.
module dma_halt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi,
    input  logic clear,
    output logic halted
);
    // Set on NMI, clear on software request, otherwise keep.
    always_ff @(posedge clk) begin
        if (!rst_n)
            halted <= 1'b0;
        else if (nmi)
            halted <= 1'b1;
        else if (clear)
            halted <= 1'b0;
    end

    // R9
    nmi_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi |=> halted);
endmodule

// File: rtl/bus_owner_fsm.sv
// Module: holds the current bus owner and applies the ownership rules at
// bus-cycle boundaries. Assumes bus_cycle_end is one cycle wide and that the
// channel choice is supplied combinationally by the picker.
module bus_owner_fsm
    import dma_arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cycle_end,
    input  logic   cpu_locked,
    input  logic   cpu_split,
    input  logic   hold_req,
    input  logic   dma_block,
    input  logic   dma_any,
    input  logic   dma_pick,
    output owner_t owner,
    output logic   grant_dma
);
    owner_t nxt_owner;
    logic   first_half;
    logic   mid_pair;
    logic   cpu_pinned;
    logic   decide;

    // Work out whether this boundary is a decision point and who wins it.
    always_comb begin
        mid_pair   = (owner == OWN_CH0 || owner == OWN_CH1) && first_half;
        cpu_pinned = (owner == OWN_CPU) && (cpu_locked || cpu_split);
        decide     = cycle_end && !mid_pair && !cpu_pinned;
        nxt_owner  = owner;
        grant_dma  = 1'b0;
        if (decide) begin
            if (hold_req)
                nxt_owner = OWN_HOLD;
            else if (!dma_block && dma_any) begin
                nxt_owner = dma_pick ? OWN_CH1 : OWN_CH0;
                grant_dma = 1'b1;
            end else
                nxt_owner = OWN_CPU;
        end
    end

    // Register the owner and track the half of a DMA transfer pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner      <= OWN_CPU;
            first_half <= 1'b0;
        end else begin
            owner <= nxt_owner;
            if (grant_dma)
                first_half <= 1'b1;
            else if (cycle_end)
                first_half <= 1'b0;
        end
    end

    // R2
    boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_end |=> (owner == $past(owner)));

    // R3
    pair_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_end && mid_pair) |=> (owner == $past(owner)));

    // R6
    lock_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_end && owner == OWN_CPU && cpu_locked) |=> (owner == OWN_CPU));

    // R7
    split_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_end && owner == OWN_CPU && cpu_split) |=> (owner == OWN_CPU));

    // R9
    halt_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && dma_block) |=> (owner == OWN_CPU || owner == OWN_HOLD));
endmodule

// File: rtl/dma_bus_arbiter.sv
// Module: top of the internal bus arbiter for two DMA channels, the CPU and
// an external hold requester. Assumes the bus interface strobes
// bus_cycle_end at every boundary; grants are decoded from one owner register.
module dma_bus_arbiter
    import dma_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_cycle_end,
    input  logic [NUM_CH-1:0] dma_req,
    input  logic             arb_mode,
    input  logic             fixed_winner,
    input  logic             cpu_locked,
    input  logic             cpu_odd_split,
    input  logic             hold_req,
    input  logic             nmi,
    input  logic             halt_clear,
    output logic             cpu_gnt,
    output logic [NUM_CH-1:0] dma_gnt,
    output logic             hold_ack,
    output logic             dma_halted
);
    owner_t owner;
    logic   any_req;
    logic   pick;
    logic   take;
    logic   block;

    // DMA is blocked by the sticky flag and by an NMI arriving right now.
    always_comb block = dma_halted | nmi;

    dma_halt_flag u_halt (
        .clk    (clk),
        .rst_n  (rst_n),
        .nmi    (nmi),
        .clear  (halt_clear),
        .halted (dma_halted)
    );

    dma_chan_pick #(.CHANNELS(NUM_CH)) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (dma_req),
        .alt_mode (arb_mode),
        .fixed_ch (fixed_winner),
        .take     (take),
        .any_req  (any_req),
        .pick     (pick)
    );

    bus_owner_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cycle_end  (bus_cycle_end),
        .cpu_locked (cpu_locked),
        .cpu_split  (cpu_odd_split),
        .hold_req   (hold_req),
        .dma_block  (block),
        .dma_any    (any_req),
        .dma_pick   (pick),
        .owner      (owner),
        .grant_dma  (take)
    );

    // Decode the owner register into one grant per requester.
    always_comb begin
        cpu_gnt    = (owner == OWN_CPU);
        dma_gnt[0] = (owner == OWN_CH0);
        dma_gnt[1] = (owner == OWN_CH1);
        hold_ack   = (owner == OWN_HOLD);
    end

    // R10
    one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({hold_ack, dma_gnt, cpu_gnt}) == 1);

    // R8
    hold_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cycle_end && hold_req && cpu_gnt && !cpu_locked && !cpu_odd_split)
        |=> hold_ack);
endmodule

// File: tb/dma_bus_arbiter_test.sv
// Bench: scoreboard. The driver applies one cycle of stimulus and queues the
// expected grants; the monitor compares after the following clock edge.
module dma_bus_arbiter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cycle_end = 1'b0;
    logic [1:0] dma_req = 2'b00;
    logic       arb_mode = 1'b0;
    logic       fixed_winner = 1'b0;
    logic       cpu_locked = 1'b0;
    logic       cpu_odd_split = 1'b0;
    logic       hold_req = 1'b0;
    logic       nmi = 1'b0;
    logic       halt_clear = 1'b0;
    logic       cpu_gnt;
    logic [1:0] dma_gnt;
    logic       hold_ack;
    logic       dma_halted;

    typedef struct {
        logic [3:0] gnt;
        logic       halt;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    localparam logic [3:0] CPU = 4'b0001;
    localparam logic [3:0] D0  = 4'b0010;
    localparam logic [3:0] D1  = 4'b0100;
    localparam logic [3:0] H   = 4'b1000;

    always #2.5 clk = ~clk;

    dma_bus_arbiter uut (
        .clk(clk), .rst_n(rst_n), .bus_cycle_end(bus_cycle_end),
        .dma_req(dma_req), .arb_mode(arb_mode), .fixed_winner(fixed_winner),
        .cpu_locked(cpu_locked), .cpu_odd_split(cpu_odd_split),
        .hold_req(hold_req), .nmi(nmi), .halt_clear(halt_clear),
        .cpu_gnt(cpu_gnt), .dma_gnt(dma_gnt), .hold_ack(hold_ack),
        .dma_halted(dma_halted)
    );

    // Driver: stimulus is already set; queue expectation and advance a cycle.
    task automatic tick(input logic [3:0] g, input logic h, input string tag);
        exp_t e;
        e.gnt = g; e.halt = h; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: one step after each rising edge, compare against the queue.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                logic [3:0] act;
                e = q.pop_front();
                act = {hold_ack, dma_gnt, cpu_gnt};
                checks++;
                if (act !== e.gnt || dma_halted !== e.halt) begin
                    errors++;
                    $display("FAIL %s: grants=%b halted=%b expected grants=%b halted=%b",
                             e.tag, act, dma_halted, e.gnt, e.halt);
                end
                checks++;
                if ($countones(act) != 1) begin
                    errors++;
                    $display("FAIL R10 one-hot: grants=%b expected exactly one bit", act);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1 reset state
        rst_n = 0; tick(CPU, 0, "R1 reset"); tick(CPU, 0, "R1 reset");
        rst_n = 1;
        // R2 no move without a boundary
        dma_req = 2'b01; bus_cycle_end = 0; tick(CPU, 0, "R2 no boundary");
        bus_cycle_end = 1; tick(D0, 0, "R4 single request ch0");
        dma_req = 2'b00; tick(D0, 0, "R3 pair second half");
        tick(CPU, 0, "R10 idle goes to CPU");
        // R4 fixed priority
        dma_req = 2'b11; fixed_winner = 1;
        tick(D1, 0, "R4 fixed ch1"); tick(D1, 0, "R3 pair");
        tick(D1, 0, "R4 fixed ch1 again"); tick(D1, 0, "R3 pair");
        fixed_winner = 0;
        tick(D0, 0, "R4 fixed ch0"); tick(D0, 0, "R3 pair");
        // R5 alternating
        arb_mode = 1;
        tick(D1, 0, "R5 alternate to ch1"); tick(D1, 0, "R3 pair");
        tick(D0, 0, "R5 alternate to ch0"); tick(D0, 0, "R3 pair");
        tick(D1, 0, "R5 alternate to ch1"); tick(D1, 0, "R3 pair");
        dma_req = 2'b00; tick(CPU, 0, "R10 idle");
        arb_mode = 0;
        // R6 / R7 CPU pinned
        dma_req = 2'b01; cpu_locked = 1;
        tick(CPU, 0, "R6 lock blocks DMA"); tick(CPU, 0, "R6 lock blocks DMA");
        cpu_locked = 0; cpu_odd_split = 1; tick(CPU, 0, "R7 odd split blocks DMA");
        cpu_odd_split = 0; bus_cycle_end = 0; tick(CPU, 0, "R2 no boundary");
        bus_cycle_end = 1; tick(D0, 0, "R6 DMA after unlock");
        tick(D0, 0, "R3 pair");
        // R8 hold beats DMA
        hold_req = 1; tick(H, 0, "R8 hold beats DMA");
        tick(H, 0, "R8 hold kept");
        hold_req = 0; tick(D0, 0, "R8 DMA after hold");
        hold_req = 1; tick(D0, 0, "R3 hold waits for pair");
        tick(H, 0, "R8 hold after pair");
        hold_req = 0; dma_req = 2'b00; tick(CPU, 0, "R10 back to CPU");
        cpu_locked = 1; hold_req = 1; tick(CPU, 0, "R6 lock blocks hold");
        cpu_locked = 0; tick(H, 0, "R8 hold after unlock");
        hold_req = 0; tick(CPU, 0, "R10 back to CPU");
        // R9 NMI halt
        dma_req = 2'b01; tick(D0, 0, "R9 before NMI");
        nmi = 1; tick(D0, 1, "R9 NMI waits for pair");
        nmi = 0; tick(CPU, 1, "R9 halted blocks DMA");
        tick(CPU, 1, "R9 halt sticky");
        halt_clear = 1; bus_cycle_end = 0; tick(CPU, 0, "R9 clear");
        nmi = 1; tick(CPU, 1, "R9 NMI beats clear");
        nmi = 0; tick(CPU, 0, "R9 clear again");
        halt_clear = 0; bus_cycle_end = 1; tick(D0, 0, "R9 DMA resumes");
        tick(D0, 0, "R3 pair");
        dma_req = 2'b00; tick(CPU, 0, "R10 idle");
        hold_req = 1; nmi = 1; tick(H, 1, "R8 hold beats NMI halt");
        hold_req = 0; nmi = 0; tick(CPU, 1, "R9 halted after hold");
        halt_clear = 1; bus_cycle_end = 0; tick(CPU, 0, "R9 clear");
        halt_clear = 0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule